// File: doc/BRIEF.md
# Transmit Bit-Clock Divider and Source Selector

This block produces the bit clock for the transmit half of a synchronous serial port. Everything runs on the master clock. The "clocks" it handles are level signals sampled by that clock.

A programmable divider produces a square wave whose high and low levels each last exactly `div_val` master-clock cycles. This gives a 50% duty cycle for odd and even divisors alike. A divisor of zero parks the divider. The divided level is also exported for the receive half of the port.

A two-bit selector chooses the transmit clock from three sources: the divided clock, a clock level supplied by the receive half, or an asynchronous clock pin that first passes through a synchronizer. An invert control then flips the chosen level. The result is registered and can be driven back out to the clock pad, with a matching output enable.

Top module: `txclk_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every output is low.
- R2: When `div_val` is 0, `div_clk_out` stays low.
- R3: With `div_val` = N ≥ 1 held steady, `div_clk_out` alternates low and high levels of exactly N cycles each, so the period is 2N cycles.
- R4: On the first clock edge that sees a new `div_val`, the divider restarts. `div_clk_out` is low after that edge and stays low for the next N cycles.
- R5: The extreme divisors work. N = 1 toggles `div_clk_out` every cycle, and N = 4095 holds each level for 4095 cycles.
- R6: `src_sel` = 0 selects the divided clock. `tx_clk` equals the value `div_clk_out` had one cycle earlier (XOR `tx_inv`).
- R7: `src_sel` = 1 selects `rx_clk_in`. `tx_clk` equals `rx_clk_in` as sampled at the previous edge (XOR `tx_inv`).
- R8: `src_sel` = 2 selects the pin. `pad_clk_in` goes through two synchronizer flops and the output register, so `tx_clk` follows the pin three edges later (XOR `tx_inv`).
- R9: `src_sel` = 3 is reserved. It drives `tx_clk` low whatever `tx_inv` is.
- R10: `tx_inv` = 1 inverts the selected source for selector values 0, 1 and 2.
- R11: `pin_edge` is high for one cycle each time the synchronised pin level changes. It rises one edge after the synchronised value changes.
- R12: `pad_clk_out` always equals `tx_clk`. `pad_clk_oe` is high exactly one edge after `src_sel` was 0 or 1, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W (12) | Divisor; 0 disables the divider |
| src_sel | input | 2 | Transmit clock source: 0 divided, 1 receive, 2 pin, 3 reserved |
| tx_inv | input | 1 | Invert the selected transmit clock |
| rx_clk_in | input | 1 | Clock level from the receive half, master-clock synchronous |
| pad_clk_in | input | 1 | Asynchronous clock level from the pad |
| div_clk_out | output | 1 | Divided clock level, shared with the receive half |
| tx_clk | output | 1 | Registered transmit clock |
| pin_edge | output | 1 | One-cycle pulse on a synchronised pin change |
| pad_clk_out | output | 1 | Level driven to the clock pad |
| pad_clk_oe | output | 1 | Pad output enable |

## Verification
The assertions assume that `rx_clk_in`, `src_sel`, `tx_inv` and `div_val` are synchronous to `clk`, since they relate registered outputs to those inputs as seen one edge earlier. Only `pad_clk_in` is allowed to be asynchronous. The stimulus changes every input on the falling clock edge, including the pin, so the synchronizer's delay is exact and the model can predict it cycle by cycle. Divisor changes are made both while the divided clock is high and while it is low, so the restart rule is covered in both states.

// File: rtl/txclk_pkg.sv
package txclk_pkg;
  typedef enum logic [1:0] {
    SRC_DIV  = 2'd0,
    SRC_RX   = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_NONE = 2'd3
  } tx_src_e;
endpackage

// File: rtl/txclk_divider.sv
module txclk_divider #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             div_clk
);
  localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);
  localparam logic [DIV_W-1:0] ZERO = '0;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic             lvl;

  // A new divisor, or zero, restarts the count with the level low.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= ZERO;
      cnt   <= ZERO;
      lvl   <= 1'b0;
    end else if (div_val != div_q || div_val == ZERO) begin
      div_q <= div_val;
      cnt   <= ZERO;
      lvl   <= 1'b0;
    end else if (cnt == div_q - ONE) begin
      cnt <= ZERO;
      lvl <= ~lvl;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  assign div_clk = lvl;
endmodule

// File: rtl/txclk_sync.sv
module txclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic pin_sync,
  output logic pin_edge
);
  logic [STAGES-1:0] chain;
  logic              last_q;
  logic              edge_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      last_q <= chain[STAGES-1];
      edge_q <= chain[STAGES-1] ^ last_q;
    end
  end

  assign pin_sync = chain[STAGES-1];
  assign pin_edge = edge_q;
endmodule

// File: rtl/txclk_mux.sv
module txclk_mux
  import txclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  tx_src_e sel,
  input  logic    inv,
  input  logic    div_clk,
  input  logic    rx_clk,
  input  logic    pin_clk,
  output logic    clk_out,
  output logic    oe_out
);
  logic pick;
  logic drive;

  always_comb begin
    pick  = 1'b0;
    drive = 1'b0;
    unique case (sel)
      SRC_DIV:  begin pick = div_clk ^ inv; drive = 1'b1; end
      SRC_RX:   begin pick = rx_clk  ^ inv; drive = 1'b1; end
      SRC_PIN:  begin pick = pin_clk ^ inv; drive = 1'b0; end
      SRC_NONE: begin pick = 1'b0;          drive = 1'b0; end
      default:  begin pick = 1'b0;          drive = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out <= 1'b0;
      oe_out  <= 1'b0;
    end else begin
      clk_out <= pick;
      oe_out  <= drive;
    end
  end
endmodule

// File: rtl/txclk_gen.sv
module txclk_gen
  import txclk_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic [1:0]       src_sel,
  input  logic             tx_inv,
  input  logic             rx_clk_in,
  input  logic             pad_clk_in,
  output logic             div_clk_out,
  output logic             tx_clk,
  output logic             pin_edge,
  output logic             pad_clk_out,
  output logic             pad_clk_oe
);
  logic pin_sync;
  logic tx_q;

  txclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .div_val (div_val),
    .div_clk (div_clk_out)
  );

  txclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pad_clk_in),
    .pin_sync (pin_sync),
    .pin_edge (pin_edge)
  );

  txclk_mux u_mux (
    .clk     (clk),
    .rst     (rst),
    .sel     (tx_src_e'(src_sel)),
    .inv     (tx_inv),
    .div_clk (div_clk_out),
    .rx_clk  (rx_clk_in),
    .pin_clk (pin_sync),
    .clk_out (tx_q),
    .oe_out  (pad_clk_oe)
  );

  assign tx_clk      = tx_q;
  assign pad_clk_out = tx_q;
endmodule

// File: rtl/txclk_gen_chk.sv
module txclk_gen_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] div_val,
  input logic [1:0]       src_sel,
  input logic             tx_inv,
  input logic             rx_clk_in,
  input logic             div_clk_out,
  input logic             tx_clk,
  input logic             pad_clk_oe
);
  assert_div_off_R2: assert property (@(posedge clk) disable iff (rst)
    (div_val == '0) |=> !div_clk_out);

  assert_restart_low_R4: assert property (@(posedge clk) disable iff (rst)
    (div_val != $past(div_val)) |=> !div_clk_out);

  assert_div_source_R6: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd0 && !tx_inv) |=> (tx_clk == $past(div_clk_out)));

  assert_rx_source_R7: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd1 && !tx_inv) |=> (tx_clk == $past(rx_clk_in)));

  assert_reserved_low_R9: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd3) |=> !tx_clk);

  assert_invert_rx_R10: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd1 && tx_inv) |=> (tx_clk == !$past(rx_clk_in)));

  assert_oe_off_R12: assert property (@(posedge clk) disable iff (rst)
    (src_sel[1]) |=> !pad_clk_oe);
endmodule

bind txclk_gen txclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .div_val     (div_val),
  .src_sel     (src_sel),
  .tx_inv      (tx_inv),
  .rx_clk_in   (rx_clk_in),
  .div_clk_out (div_clk_out),
  .tx_clk      (tx_clk),
  .pad_clk_oe  (pad_clk_oe)
);

// File: tb/txclk_gen_tb.sv
module txclk_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 12;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] div_val = '0;
  logic [1:0]       src_sel = 2'd0;
  logic             tx_inv = 1'b0;
  logic             rx_clk_in = 1'b0;
  logic             pad_clk_in = 1'b0;
  logic             div_clk_out, tx_clk, pin_edge, pad_clk_out, pad_clk_oe;

  txclk_gen #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .div_val(div_val), .src_sel(src_sel), .tx_inv(tx_inv),
    .rx_clk_in(rx_clk_in), .pad_clk_in(pad_clk_in), .div_clk_out(div_clk_out),
    .tx_clk(tx_clk), .pin_edge(pin_edge), .pad_clk_out(pad_clk_out),
    .pad_clk_oe(pad_clk_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model.
  int  m_div = 0;
  int  m_k = 0;
  bit  m_dclk = 0, m_tx = 0, m_edge = 0, m_oe = 0;
  bit  hist[$] = '{0, 0, 0};
  int  cycles = 0;
  int  vectors = 0, misses = 0;
  string tag = "R1";
  bit  rx_gen = 0, pad_gen = 0;
  int  lfsr = 32'h1234_5678;

  function automatic bit div_level(int d, int k);
    if (d == 0) return 1'b0;
    return ((k / d) % 2) == 1;
  endfunction

  always @(posedge clk) begin
    bit src;
    cycles++;
    if (rst) begin
      m_div = 0; m_k = 0; m_dclk = 0; m_tx = 0; m_edge = 0; m_oe = 0;
      hist = '{0, 0, 0};
    end else begin
      case (src_sel)
        2'd0: src = m_dclk ^ tx_inv;
        2'd1: src = rx_clk_in ^ tx_inv;
        2'd2: src = hist[1] ^ tx_inv;
        default: src = 1'b0;
      endcase
      m_tx   = src;
      m_oe   = (src_sel == 2'd0 || src_sel == 2'd1);
      m_edge = hist[1] != hist[2];
      hist.push_front(pad_clk_in);
      void'(hist.pop_back());
      if (int'(div_val) != m_div || div_val == '0) begin
        m_div = int'(div_val); m_k = 0;
      end else begin
        m_k++;
      end
      m_dclk = div_level(m_div, m_k);
    end
  end

  task automatic cmp(string sig, bit act, bit exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", tag, sig, cycles, act, exp);
    end
  endtask

  // Compare every output on every falling edge, then drive generated stimulus.
  always @(negedge clk) begin
    cmp("div_clk_out", div_clk_out, m_dclk);
    cmp("tx_clk",      tx_clk,      m_tx);
    cmp("pin_edge",    pin_edge,    m_edge);
    cmp("pad_clk_out", pad_clk_out, m_tx);
    cmp("pad_clk_oe",  pad_clk_oe,  m_oe);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    if (rx_gen)  rx_clk_in  = lfsr[3];
    if (pad_gen && lfsr[7:6] != 2'b00) pad_clk_in = ~pad_clk_in;
    if (cycles > WATCHDOG) begin
      misses++;
      $display("FAIL watchdog expired: actual=%0d cycles expected=finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R1"; rst = 1'b1; div_val = 12'd3;
    run(4);
    @(negedge clk); rst = 1'b0;
    run(2);
    tag = "R2 R6"; div_val = '0; src_sel = 2'd0;
    run(20);
    tag = "R3 R6"; div_val = 12'd3;
    run(30);
    tag = "R3 R10"; div_val = 12'd4; tx_inv = 1'b1;
    run(41);
    tag = "R4"; div_val = 12'd2; tx_inv = 1'b0;   // change taken mid-period
    run(9);
    div_val = 12'd5;
    run(23);
    tag = "R5"; div_val = 12'd1;
    run(16);
    div_val = 12'd4095;
    run(8300);
    tag = "R7 R12"; div_val = 12'd6; src_sel = 2'd1; rx_gen = 1'b1;
    run(60);
    tag = "R7 R10"; tx_inv = 1'b1;
    run(60);
    tag = "R8 R11 R12"; src_sel = 2'd2; tx_inv = 1'b0; rx_gen = 1'b0; pad_gen = 1'b1;
    run(80);
    tag = "R8 R10"; tx_inv = 1'b1;
    run(60);
    tag = "R9 R12"; src_sel = 2'd3;
    run(20);
    tx_inv = 1'b0;
    run(20);
    tag = "R12"; pad_gen = 1'b0;
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      run(7);
    end
    tag = "R1"; rst = 1'b1;
    run(3);
    rst = 1'b0;
    run(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule